// File: doc/BRIEF.md
# Outstanding Miss Entry Table

This block keeps the record of cache misses that are still in flight. Each entry records a block address, a secure bit, a thread number, the cycle at which the miss may be sent downstream and a small count of waiting requesters. A controller drives one command per cycle on a shared command port. The commands allocate an entry, send an entry downstream, return it to the waiting set, move it to the front, release it, add or remove a requester, squash by thread and request a drain.

Entries that are allocated but not yet sent are kept in a waiting order. The order sorts them by ready cycle, with the older entry first on a tie, and an entry moved to the front goes ahead of all of them. The head of that order is shown on an issue port. A separate lookup port reports whether an address and secure bit pair is already held. The physical table is sized from a requested count plus a reserve, so that a few extra misses can still be absorbed once the table reports full.

Top module: `mshr_table`

## Requirements
- R1: The table holds REQ_ENTRIES + RESERVE - 1 entries (5 with the defaults). `alloc_count` gives the number held, and `full` is high exactly when every entry is held. After any command both are updated at the same clock edge as the command.
- R2: Command code 1 (allocate) takes the lowest-numbered free entry, with one requester and no in-service mark. On the next edge it pulses `alloc_ok` with that entry's number on `alloc_idx`. While `full` is high the command is dropped: there is no `alloc_ok` and the count is unchanged.
- R3: A lookup reports a hit, one edge after it is presented, only when an allocated entry matches both the address and the secure bit. When several entries match, the lowest number is reported.
- R4: The issue port shows the head of the waiting order (allocated, not in service). Front-moved entries come first, the most recently moved leading. The rest follow sorted by ready cycle ascending, and equal ready cycles keep their insertion order. `iss_valid` is high only when the head's ready cycle is at or below the internal cycle count, which starts at 0 on reset. Issue outputs lag the table state by one edge.
- R5: Command code 2 (serve) on a waiting entry with `cmd_resp`=1 takes it out of the waiting order and raises `svc_count`. With `cmd_resp`=0 it releases the entry instead.
- R6: Command code 3 (re-wait) on an in-service entry clears its in-service mark, lowers `svc_count` and puts it back into the waiting order by ready cycle, behind entries with an equal ready cycle. On an entry that is not in service it has no effect.
- R7: Command code 4 (to-front) puts a waiting entry at the head of the order. It has no effect on an in-service entry.
- R8: Command code 5 (release) frees an allocated entry and lowers `alloc_count`, and also `svc_count` if the entry was in service.
- R9: Command code 6 adds a requester to an entry, saturating at the maximum. Command code 7 removes one, and releases the entry when it had at most one. Code 7 pulses `unfull` when it takes the table from full to not full.
- R10: Command code 8 (squash) clears the requesters of every allocated entry whose thread equals `cmd_tid`. Such entries that are waiting are released. Such entries that are in service stay allocated with zero requesters.
- R11: Command code 9 (drain) with an empty table pulses `drain_done` on the next edge. Otherwise it raises `draining`, and `drain_done` pulses, with `draining` dropping, on the edge at which the last entry is released.
- R12: After reset the table is empty, and `full`, `iss_valid`, `lk_hit`, `alloc_ok`, `unfull`, `draining` and `drain_done` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_idx | input | IW | Entry number the command targets |
| cmd_addr | input | AW | Block address for allocate |
| cmd_secure | input | 1 | Secure bit for allocate |
| cmd_tid | input | TIDW | Thread for allocate and squash |
| cmd_rtime | input | TW | Ready cycle for allocate |
| cmd_resp | input | 1 | Serve expects a response |
| lk_addr | input | AW | Lookup address |
| lk_secure | input | 1 | Lookup secure bit |
| lk_hit | output | 1 | Lookup matched |
| lk_idx | output | IW | Matching entry |
| alloc_ok | output | 1 | Allocate accepted (pulse) |
| alloc_idx | output | IW | Entry given by allocate |
| full | output | 1 | All entries held |
| alloc_count | output | IW+1 | Entries held |
| svc_count | output | IW+1 | Entries in service |
| iss_valid | output | 1 | Head of waiting order is ready |
| iss_idx | output | IW | Head entry number |
| iss_addr | output | AW | Head entry address |
| iss_secure | output | 1 | Head entry secure bit |
| unfull | output | 1 | Remove-requester left the full state (pulse) |
| draining | output | 1 | Drain pending |
| drain_done | output | 1 | Drain complete (pulse) |

## Verification
Counts, `full`, `alloc_ok`, `unfull`, `draining` and `drain_done` follow the table state. They are due at the clock edge that takes the command, so the bench drives each command half a cycle before an edge and samples at the falling edge just after it. The issue and lookup outputs are registered from that updated state and are due one edge later, so the bench waits one extra cycle before reading them. Ordering and ready-time checks run only after the internal cycle count has passed every ready cycle the bench uses, except for the entry whose ready cycle is deliberately out of reach.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [3:0] {
    OP_NOP    = 4'd0,
    OP_ALLOC  = 4'd1,
    OP_SERVE  = 4'd2,
    OP_REWAIT = 4'd3,
    OP_FRONT  = 4'd4,
    OP_FREE   = 4'd5,
    OP_ADDT   = 4'd6,
    OP_POPT   = 4'd7,
    OP_SQUASH = 4'd8,
    OP_DRAIN  = 4'd9
  } mshr_op_e;
endpackage

// File: rtl/mshr_lowest.sv
module mshr_lowest #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mshr_match.sv
module mshr_match #(
  parameter int N  = 5,
  parameter int IW = 3,
  parameter int AW = 12
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][AW-1:0] tab_addr,
  input  logic [N-1:0]         tab_sec,
  input  logic [AW-1:0]        key_addr,
  input  logic                 key_sec,
  output logic                 hit,
  output logic [IW-1:0]        idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = valid[g] && (tab_addr[g] == key_addr) && (tab_sec[g] == key_sec);
  end

  mshr_lowest #(.N(N), .IW(IW)) u_enc (.req(eq), .found(hit), .idx(idx));
endmodule

// File: rtl/mshr_pick.sv
module mshr_pick #(
  parameter int N  = 5,
  parameter int IW = 3,
  parameter int TW = 16,
  parameter int SW = 16
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0]         front,
  input  logic [N-1:0][TW-1:0] rtime,
  input  logic [N-1:0][SW-1:0] stamp,
  output logic                 found,
  output logic [IW-1:0]        idx
);
  function automatic logic ahead(input logic fa, input logic [TW-1:0] ra, input logic [SW-1:0] sa,
                                 input logic fb, input logic [TW-1:0] rb, input logic [SW-1:0] sb);
    if (fa != fb) return fa;
    if (fa) return sa > sb;
    if (ra != rb) return ra < rb;
    return sa < sb;
  endfunction

  always_comb begin
    int best;
    best  = 0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || ahead(front[i], rtime[i], stamp[i], front[best], rtime[best], stamp[best]))) begin
        best  = i;
        found = 1'b1;
      end
    end
    idx = IW'(best);
  end
endmodule

// File: rtl/mshr_table.sv
module mshr_table
  import mshr_pkg::*;
#(
  parameter int REQ_ENTRIES = 4,
  parameter int RESERVE     = 2,
  parameter int AW          = 12,
  parameter int TIDW        = 2,
  parameter int TW          = 16,
  parameter int SW          = 16,
  parameter int TGW         = 3,
  localparam int NENT       = REQ_ENTRIES + RESERVE - 1,
  localparam int IW         = (NENT > 1) ? $clog2(NENT) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_valid,
  input  logic [3:0]      cmd_op,
  input  logic [IW-1:0]   cmd_idx,
  input  logic [AW-1:0]   cmd_addr,
  input  logic            cmd_secure,
  input  logic [TIDW-1:0] cmd_tid,
  input  logic [TW-1:0]   cmd_rtime,
  input  logic            cmd_resp,
  input  logic [AW-1:0]   lk_addr,
  input  logic            lk_secure,
  output logic            lk_hit,
  output logic [IW-1:0]   lk_idx,
  output logic            alloc_ok,
  output logic [IW-1:0]   alloc_idx,
  output logic            full,
  output logic [IW:0]     alloc_count,
  output logic [IW:0]     svc_count,
  output logic            iss_valid,
  output logic [IW-1:0]   iss_idx,
  output logic [AW-1:0]   iss_addr,
  output logic            iss_secure,
  output logic            unfull,
  output logic            draining,
  output logic            drain_done
);
  localparam logic [IW:0]    FULLC  = (IW+1)'(NENT);
  localparam logic [TGW-1:0] TG_ONE = TGW'(1);
  localparam logic [TGW-1:0] TG_MAX = '1;
  localparam logic [SW-1:0]  ST_ONE = SW'(1);
  localparam logic [TW-1:0]  TW_ONE = TW'(1);

  // Entry state
  logic [NENT-1:0]           v_q, v_n, svc_q, svc_n, fr_q, fr_n, se_q, se_n;
  logic [NENT-1:0][AW-1:0]   ad_q, ad_n;
  logic [NENT-1:0][TIDW-1:0] td_q, td_n;
  logic [NENT-1:0][TW-1:0]   rt_q, rt_n;
  logic [NENT-1:0][SW-1:0]   st_q, st_n;
  logic [NENT-1:0][TGW-1:0]  tg_q, tg_n;
  logic [SW-1:0]             stc_q, stc_n;
  logic [TW-1:0]             now_q;

  logic [IW:0]   cnt_n, scnt_n;
  logic          dr_n, done_n, aok_n, unf_n;
  logic          free_ok, m_hit, p_found;
  logic [IW-1:0] free_idx, m_idx, p_idx;
  logic          idx_ok;
  mshr_op_e      op;

  assign op     = mshr_op_e'(cmd_op);
  assign idx_ok = (int'(cmd_idx) < NENT);

  mshr_lowest #(.N(NENT), .IW(IW)) u_free (.req(~v_q), .found(free_ok), .idx(free_idx));

  mshr_match #(.N(NENT), .IW(IW), .AW(AW)) u_match (
    .valid(v_q), .tab_addr(ad_q), .tab_sec(se_q),
    .key_addr(lk_addr), .key_sec(lk_secure), .hit(m_hit), .idx(m_idx));

  mshr_pick #(.N(NENT), .IW(IW), .TW(TW), .SW(SW)) u_pick (
    .cand(v_q & ~svc_q), .front(fr_q), .rtime(rt_q), .stamp(st_q),
    .found(p_found), .idx(p_idx));

  always_comb begin
    v_n = v_q;   svc_n = svc_q; fr_n = fr_q; se_n = se_q;
    ad_n = ad_q; td_n = td_q;   rt_n = rt_q; st_n = st_q;
    tg_n = tg_q; stc_n = stc_q;
    dr_n = draining; done_n = 1'b0; aok_n = 1'b0; unf_n = 1'b0;
    if (cmd_valid) begin
      unique case (op)
        OP_ALLOC: if (free_ok) begin
          v_n[free_idx]   = 1'b1;
          svc_n[free_idx] = 1'b0;
          fr_n[free_idx]  = 1'b0;
          ad_n[free_idx]  = cmd_addr;
          se_n[free_idx]  = cmd_secure;
          td_n[free_idx]  = cmd_tid;
          rt_n[free_idx]  = cmd_rtime;
          st_n[free_idx]  = stc_q;
          tg_n[free_idx]  = TG_ONE;
          stc_n           = stc_q + ST_ONE;
          aok_n           = 1'b1;
        end
        OP_SERVE: if (idx_ok && v_q[cmd_idx] && !svc_q[cmd_idx]) begin
          if (cmd_resp) svc_n[cmd_idx] = 1'b1;
          else          v_n[cmd_idx]   = 1'b0;
        end
        OP_REWAIT: if (idx_ok && v_q[cmd_idx] && svc_q[cmd_idx]) begin
          svc_n[cmd_idx] = 1'b0;
          fr_n[cmd_idx]  = 1'b0;
          st_n[cmd_idx]  = stc_q;
          stc_n          = stc_q + ST_ONE;
        end
        OP_FRONT: if (idx_ok && v_q[cmd_idx] && !svc_q[cmd_idx]) begin
          fr_n[cmd_idx] = 1'b1;
          st_n[cmd_idx] = stc_q;
          stc_n         = stc_q + ST_ONE;
        end
        OP_FREE: if (idx_ok) v_n[cmd_idx] = 1'b0;
        OP_ADDT: if (idx_ok && v_q[cmd_idx] && tg_q[cmd_idx] != TG_MAX)
          tg_n[cmd_idx] = tg_q[cmd_idx] + TG_ONE;
        OP_POPT: if (idx_ok && v_q[cmd_idx]) begin
          if (tg_q[cmd_idx] <= TG_ONE) v_n[cmd_idx]  = 1'b0;
          else                         tg_n[cmd_idx] = tg_q[cmd_idx] - TG_ONE;
        end
        OP_SQUASH: for (int i = 0; i < NENT; i++) begin
          if (v_q[i] && td_q[i] == cmd_tid) begin
            tg_n[i] = '0;
            if (!svc_q[i]) v_n[i] = 1'b0;
          end
        end
        OP_DRAIN: if (alloc_count == '0) done_n = 1'b1;
                  else                   dr_n   = 1'b1;
        default: ;
      endcase
    end
    // released entries lose every mark
    for (int i = 0; i < NENT; i++) begin
      if (!v_n[i]) begin
        svc_n[i] = 1'b0;
        fr_n[i]  = 1'b0;
        tg_n[i]  = '0;
      end
    end
    cnt_n  = (IW+1)'($countones(v_n));
    scnt_n = (IW+1)'($countones(v_n & svc_n));
    if (draining && cnt_n == '0) begin
      done_n = 1'b1;
      dr_n   = 1'b0;
    end
    if (cmd_valid && op == OP_POPT && full && cnt_n != FULLC) unf_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0; svc_q <= '0; fr_q <= '0; se_q <= '0;
      ad_q <= '0; td_q <= '0; rt_q <= '0; st_q <= '0; tg_q <= '0;
      stc_q <= '0; now_q <= '0;
      alloc_count <= '0; svc_count <= '0; full <= 1'b0;
      alloc_ok <= 1'b0; alloc_idx <= '0; unfull <= 1'b0;
      draining <= 1'b0; drain_done <= 1'b0;
      lk_hit <= 1'b0; lk_idx <= '0;
      iss_valid <= 1'b0; iss_idx <= '0; iss_addr <= '0; iss_secure <= 1'b0;
    end else begin
      v_q <= v_n; svc_q <= svc_n; fr_q <= fr_n; se_q <= se_n;
      ad_q <= ad_n; td_q <= td_n; rt_q <= rt_n; st_q <= st_n; tg_q <= tg_n;
      stc_q <= stc_n; now_q <= now_q + TW_ONE;
      alloc_count <= cnt_n; svc_count <= scnt_n; full <= (cnt_n == FULLC);
      alloc_ok <= aok_n; alloc_idx <= free_idx; unfull <= unf_n;
      draining <= dr_n; drain_done <= done_n;
      lk_hit <= m_hit; lk_idx <= m_idx;
      iss_valid  <= p_found && (rt_q[p_idx] <= now_q);
      iss_idx    <= p_idx;
      iss_addr   <= ad_q[p_idx];
      iss_secure <= se_q[p_idx];
    end
  end
endmodule

// File: rtl/mshr_table_chk.sv
module mshr_table_chk #(
  parameter int NENT = 5,
  parameter int IW   = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          full,
  input logic          alloc_ok,
  input logic [IW:0]   alloc_count,
  input logic [IW:0]   svc_count,
  input logic          unfull,
  input logic          draining,
  input logic          drain_done
);
  localparam logic [IW:0] CAP = (IW+1)'(NENT);
  localparam logic [IW:0] ONE = (IW+1)'(1);

  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    alloc_count <= CAP);

  a_r2_full_drops: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 4'd1 && full) |=> (!alloc_ok && $stable(alloc_count)));

  a_r2_alloc_grows: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 4'd1 && !full) |=> (alloc_ok && alloc_count == $past(alloc_count) + ONE));

  a_r5_svc_within: assert property (@(posedge clk) disable iff (rst)
    svc_count <= alloc_count);

  a_r9_unfull_edge: assert property (@(posedge clk) disable iff (rst)
    unfull |-> ($past(full) && !full));

  a_r11_done_empty: assert property (@(posedge clk) disable iff (rst)
    drain_done |-> (alloc_count == '0 && !draining));
endmodule

bind mshr_table mshr_table_chk #(.NENT(NENT), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .full(full), .alloc_ok(alloc_ok), .alloc_count(alloc_count),
  .svc_count(svc_count), .unfull(unfull), .draining(draining),
  .drain_done(drain_done));

// File: tb/sim_mshr_table.sv
`timescale 1ns/1ps
module sim_mshr_table;
  import mshr_pkg::*;
  localparam int AW = 12, TIDW = 2, TW = 16, IW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_secure = 1'b0, cmd_resp = 1'b0, lk_secure = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [IW-1:0] cmd_idx = '0;
  logic [AW-1:0] cmd_addr = '0, lk_addr = '0;
  logic [TIDW-1:0] cmd_tid = '0;
  logic [TW-1:0] cmd_rtime = '0;
  logic lk_hit, alloc_ok, full, iss_valid, iss_secure, unfull, draining, drain_done;
  logic [IW-1:0] lk_idx, alloc_idx, iss_idx;
  logic [IW:0] alloc_count, svc_count;
  logic [AW-1:0] iss_addr;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  mshr_table u0 (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic cmd(input mshr_op_e op, input int idx, input int addr = 0, input bit sec = 0,
                     input int tid = 0, input int rt = 0, input bit resp = 1);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = IW'(idx); cmd_addr = AW'(addr);
    cmd_secure = sec; cmd_tid = TIDW'(tid); cmd_rtime = TW'(rt); cmd_resp = resp;
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int rts[5] = '{30, 10, 30, 10, 20};
    int order[5] = '{1, 3, 4, 0, 2};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk("R12 count", alloc_count, 0);
    chk("R12 full", full, 0);
    chk("R12 iss_valid", iss_valid, 0);
    chk("R12 lk_hit", lk_hit, 0);
    chk("R12 draining", draining, 0);
    // R11 drain of empty table
    cmd(OP_DRAIN, 0);
    chk("R11 empty done", drain_done, 1);
    chk("R11 empty draining", draining, 0);
    repeat (200) @(negedge clk);
    // R1/R2 fill the table
    for (int i = 0; i < 5; i++) begin
      cmd(OP_ALLOC, 0, 100 + i, bit'(i % 2), i % 4, rts[i]);
      chk("R2 alloc_ok", alloc_ok, 1);
      chk("R2 alloc_idx", alloc_idx, i);
      chk("R1 count", alloc_count, i + 1);
    end
    chk("R1 full", full, 1);
    cmd(OP_ALLOC, 0, 999);
    chk("R2 full drop ok", alloc_ok, 0);
    chk("R2 full drop count", alloc_count, 5);
    // R3 lookup sweep
    for (int i = 0; i < 5; i++) begin
      lk_addr = AW'(100 + i); lk_secure = bit'(i % 2);
      tick();
      chk("R3 hit", lk_hit, 1);
      chk("R3 idx", lk_idx, i);
      lk_secure = ~bit'(i % 2);
      tick();
      chk("R3 secure miss", lk_hit, 0);
    end
    // R4/R5 issue order with ties in arrival order
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R4 valid", iss_valid, 1);
      chk("R4 head", iss_idx, order[k]);
      chk("R4 addr", iss_addr, 100 + order[k]);
      cmd(OP_SERVE, order[k]);
      chk("R5 svc_count", svc_count, k + 1);
    end
    tick();
    chk("R5 none waiting", iss_valid, 0);
    // R6/R7
    cmd(OP_REWAIT, 0);
    cmd(OP_REWAIT, 3);
    chk("R6 svc drop", svc_count, 3);
    tick();
    chk("R6 reorder", iss_idx, 3);
    cmd(OP_FRONT, 0);
    tick();
    chk("R7 front", iss_idx, 0);
    cmd(OP_FRONT, 1);
    tick();
    chk("R7 in-service ignored", iss_idx, 0);
    cmd(OP_REWAIT, 0);
    chk("R6 waiting ignored", svc_count, 3);
    // R8 release
    cmd(OP_FREE, 0);
    chk("R8 count", alloc_count, 4);
    chk("R8 full", full, 0);
    tick();
    chk("R8 head", iss_idx, 3);
    cmd(OP_FREE, 3);
    tick();
    chk("R8 no waiting", iss_valid, 0);
    cmd(OP_REWAIT, 2);
    tick();
    chk("R6 back", iss_idx, 2);
    // R10 squash: tid of 1 is 1, of 2 is 2, of 4 is 0
    cmd(OP_SQUASH, 0, 0, 0, 2);
    chk("R10 waiting released", alloc_count, 2);
    cmd(OP_SQUASH, 0, 0, 0, 1);
    chk("R10 in-service kept", alloc_count, 2);
    cmd(OP_POPT, 1);
    chk("R10 zero targets", alloc_count, 1);
    chk("R10 svc", svc_count, 1);
    // R9 targets, R5 serve without response
    cmd(OP_ALLOC, 0, 300);
    chk("R2 lowest free", alloc_idx, 0);
    cmd(OP_ADDT, 0);
    cmd(OP_POPT, 0);
    chk("R9 kept", alloc_count, 2);
    cmd(OP_POPT, 0);
    chk("R9 released", alloc_count, 1);
    cmd(OP_ALLOC, 0, 301);
    cmd(OP_SERVE, 0, 0, 0, 0, 0, 0);
    chk("R5 no-resp release", alloc_count, 1);
    chk("R5 no-resp svc", svc_count, 1);
    // R9 unfull
    for (int i = 0; i < 4; i++) cmd(OP_ALLOC, 0, 400 + i, 0, 3);
    chk("R1 full again", full, 1);
    cmd(OP_POPT, 2);
    chk("R9 unfull", unfull, 1);
    chk("R9 not full", full, 0);
    // R4 ready time not reached
    cmd(OP_FREE, 0); cmd(OP_FREE, 1); cmd(OP_FREE, 3);
    cmd(OP_ALLOC, 0, 500, 0, 0, 65535);
    tick();
    chk("R4 future idx", iss_idx, 0);
    chk("R4 future not valid", iss_valid, 0);
    // R11 drain with entries
    cmd(OP_DRAIN, 0);
    chk("R11 draining", draining, 1);
    chk("R11 not done", drain_done, 0);
    cmd(OP_FREE, 4);
    chk("R11 still waiting", drain_done, 0);
    cmd(OP_FREE, 0);
    chk("R11 done", drain_done, 1);
    chk("R11 drain cleared", draining, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule